// File: doc/BRIEF.md
# Chained Multi-Element Datapath with Full Crossbar

This block is the execution core of a statically scheduled datapath. It holds a parameterised number of identical compute elements. Each element is a 2x2 grid of nodes arranged in two rows. Each node computes either a product or an ALU result on two 16-bit operands, or it stays idle.

The first row reads its operands from a shared 16-entry register bank. The second row picks each operand from one of four places: its own element's first-row outputs, an external port, or an immediate in the configuration word. Every external port is fed by a full crossbar. The crossbar can route the bank or any first-row result of any element to any external second-row operand. Because of this, a chain of dependent operations that crosses element boundaries settles within one cycle.

Each clock cycle runs one control step. The step is described entirely by the configuration inputs: node operations, bank read addresses, crossbar selects, second-row operand selects, immediate, and write-back enables and addresses. Every node result is visible on `res_o` in the same cycle. Any result can be written back to the bank at the clock edge, but only when the step is marked valid.

Top module: `xbar_datapath`

## Requirements
- R1: After the asynchronous active-low reset every bank entry reads 0 and `done_o` is 0.
- R2: Node operation codes are: 1 pass a, 2 a+b, 3 a-b, 4 low 16 bits of a*b, 5 and, 6 or, 7 xor, 8 a shifted left by b[3:0], 9 a shifted right logically by b[3:0]. All arithmetic wraps modulo 2^16.
- R3: Each second-row operand takes a 2-bit select. Value 0 picks the element's first first-row result, 1 picks the second, 2 picks its external port, and 3 picks `imm_i`.
- R4: External port d (element d/4; order: lower node a, lower node b, upper node a, upper node b) has its own crossbar select and bank address. Select 0 gives bank[ext address]. Select k in 1..2p gives first-row result k-1, with first-row results numbered element*2+node. Any larger select gives 0.
- R5: A chain that runs through another element via the crossbar produces its final result on `res_o` in the same cycle, and that result can be written back at the next edge.
- R6: Bank reads are combinational. Result slot k (slot = element*4 + node, with nodes 0 and 1 in the first row) is written to bank[`wb_addr_i` field k] at the rising edge only when `valid_i` and `wb_en_i[k]` are both high.
- R7: When several write ports target the same address in one step, the highest-numbered port's value is stored.
- R8: While `valid_i` is low, no bank entry changes, whatever the write enables are.
- R9: `done_o` is high in the cycle after each valid step and low after each non-valid step.
- R10: A node whose operation code is 0, or any code above 9, outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Configuration word for this step is valid |
| imm_i | input | 16 | Immediate operand shared by second-row nodes |
| node_op_i | input | 4*4p | Operation code per node, node n at bits [4n+:4] |
| opnd_addr_i | input | 4*4p | Bank addresses of first-row operands |
| ext_addr_i | input | 4*4p | Bank addresses used by external ports on select 0 |
| xbar_sel_i | input | 4p*ceil(log2(2p+1)) | Crossbar select per external port |
| mux_sel_i | input | 2*4p | Second-row operand select per external port |
| wb_en_i | input | 4p | Write enable per result slot |
| wb_addr_i | input | 4*4p | Write address per result slot |
| res_o | output | 16*4p | All node results, slot k at bits [16k+:16] |
| done_o | output | 1 | Step completion, one cycle after a valid step |

## Verification
A corrupted bank entry stays hidden until a later step reads it. It then shows up as a wrong first-row result in that same combinational cycle, so the bench reads back every entry it predicts after each write sweep. Crossbar or operand-mux misrouting shows up immediately on `res_o` as the value of the wrong source. Each select value is swept with distinct register contents so that no two sources coincide. Write-priority and valid-gating faults appear one edge after the step, when the affected address is read back.

// File: rtl/xbar_datapath_pkg.sv
package xbar_datapath_pkg;
  localparam int OP_W  = 4;
  localparam int MUX_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_OFF  = 4'd0,
    OP_PASS = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd3,
    OP_MUL  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9
  } node_op_e;

  typedef enum logic [MUX_W-1:0] {
    MX_ROW_A = 2'd0,
    MX_ROW_B = 2'd1,
    MX_EXT   = 2'd2,
    MX_IMM   = 2'd3
  } opnd_sel_e;
endpackage

// File: rtl/dp_node.sv
module dp_node
  import xbar_datapath_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   y_o
);
  localparam int SH_W = $clog2(DW);

  logic [2*DW-1:0] prod;
  logic [SH_W-1:0] sh;

  assign prod = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
  assign sh   = b_i[SH_W-1:0];

  always_comb begin
    case (op_i)
      OP_PASS: y_o = a_i;
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_MUL:  y_o = prod[DW-1:0];
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_SHL:  y_o = a_i << sh;
      OP_SHR:  y_o = a_i >> sh;
      default: y_o = '0;  // idle node drives zero
    endcase
  end
endmodule

// File: rtl/dp_elem.sv
module dp_elem
  import xbar_datapath_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [4*OP_W-1:0]  op_i,
  input  logic [4*DW-1:0]    opnd_i,
  input  logic [4*DW-1:0]    ext_i,
  input  logic [4*MUX_W-1:0] mux_i,
  input  logic [DW-1:0]      imm_i,
  output logic [4*DW-1:0]    out_o
);
  logic [DW-1:0] row1 [2];
  logic [DW-1:0] opnd2 [4];

  for (genvar j = 0; j < 2; j++) begin : g_row1
    dp_node #(.DW(DW)) u_node (
      .op_i (op_i[j*OP_W +: OP_W]),
      .a_i  (opnd_i[(2*j)*DW +: DW]),
      .b_i  (opnd_i[(2*j+1)*DW +: DW]),
      .y_o  (row1[j])
    );
    assign out_o[j*DW +: DW] = row1[j];
  end

  for (genvar q = 0; q < 4; q++) begin : g_mux
    always_comb begin
      case (mux_i[q*MUX_W +: MUX_W])
        MX_ROW_A: opnd2[q] = row1[0];
        MX_ROW_B: opnd2[q] = row1[1];
        MX_EXT:   opnd2[q] = ext_i[q*DW +: DW];
        default:  opnd2[q] = imm_i;
      endcase
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_row2
    dp_node #(.DW(DW)) u_node (
      .op_i (op_i[(j+2)*OP_W +: OP_W]),
      .a_i  (opnd2[2*j]),
      .b_i  (opnd2[2*j+1]),
      .y_o  (out_o[(j+2)*DW +: DW])
    );
  end
endmodule

// File: rtl/dp_xbar.sv
module dp_xbar #(
  parameter int NSRC = 4,
  parameter int NDST = 8,
  parameter int DW   = 16,
  parameter int SW   = 3
) (
  input  logic [NSRC*DW-1:0] src_i,
  input  logic [NDST*DW-1:0] rf_i,
  input  logic [NDST*SW-1:0] sel_i,
  output logic [NDST*DW-1:0] dst_o
);
  for (genvar d = 0; d < NDST; d++) begin : g_dst
    logic [SW-1:0] sel;
    assign sel = sel_i[d*SW +: SW];
    always_comb begin
      dst_o[d*DW +: DW] = '0;
      if (sel == '0) dst_o[d*DW +: DW] = rf_i[d*DW +: DW];
      for (int k = 0; k < NSRC; k++) begin
        if (sel == SW'(k + 1)) dst_o[d*DW +: DW] = src_i[k*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/dp_regbank.sv
module dp_regbank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int NRD   = 16,
  parameter int NWR   = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NRD*AW-1:0] raddr_i,
  output logic [NRD*DW-1:0] rdata_o,
  input  logic [NWR-1:0]    we_i,
  input  logic [NWR*AW-1:0] waddr_i,
  input  logic [NWR*DW-1:0] wdata_i,
  output logic [DEPTH*DW-1:0] mem_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      // ascending order: later (higher) port overrides
      for (int k = 0; k < NWR; k++) begin
        if (we_i[k]) mem[waddr_i[k*AW +: AW]] <= wdata_i[k*DW +: DW];
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r*DW +: DW] = mem[raddr_i[r*AW +: AW]];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign mem_o[i*DW +: DW] = mem[i];
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_datapath_pkg::*;
#(
  parameter int NUM_ELEM = 2,
  parameter int DW       = 16,
  parameter int DEPTH    = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int NNODE   = 4 * NUM_ELEM,
  localparam int NSRC    = 2 * NUM_ELEM,
  localparam int SW      = $clog2(NSRC + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [DW-1:0]         imm_i,
  input  logic [NNODE*OP_W-1:0] node_op_i,
  input  logic [NNODE*AW-1:0]   opnd_addr_i,
  input  logic [NNODE*AW-1:0]   ext_addr_i,
  input  logic [NNODE*SW-1:0]   xbar_sel_i,
  input  logic [NNODE*MUX_W-1:0] mux_sel_i,
  input  logic [NNODE-1:0]      wb_en_i,
  input  logic [NNODE*AW-1:0]   wb_addr_i,
  output logic [NNODE*DW-1:0]   res_o,
  output logic                  done_o
);
  logic [2*NNODE*DW-1:0] rd_data;
  logic [NNODE*DW-1:0]   ext_val;
  logic [NSRC*DW-1:0]    row1_res;
  logic [NNODE-1:0]      wr_en;
  logic [DEPTH*DW-1:0]   rf_flat;

  assign wr_en = wb_en_i & {NNODE{valid_i}};

  dp_regbank #(
    .DW(DW), .DEPTH(DEPTH), .NRD(2*NNODE), .NWR(NNODE), .AW(AW)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i ({ext_addr_i, opnd_addr_i}),
    .rdata_o (rd_data),
    .we_i    (wr_en),
    .waddr_i (wb_addr_i),
    .wdata_i (res_o),
    .mem_o   (rf_flat)
  );

  dp_xbar #(
    .NSRC(NSRC), .NDST(NNODE), .DW(DW), .SW(SW)
  ) u_xbar (
    .src_i (row1_res),
    .rf_i  (rd_data[2*NNODE*DW-1 : NNODE*DW]),
    .sel_i (xbar_sel_i),
    .dst_o (ext_val)
  );

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    dp_elem #(.DW(DW)) u_elem (
      .op_i   (node_op_i[e*4*OP_W +: 4*OP_W]),
      .opnd_i (rd_data[e*4*DW +: 4*DW]),
      .ext_i  (ext_val[e*4*DW +: 4*DW]),
      .mux_i  (mux_sel_i[e*4*MUX_W +: 4*MUX_W]),
      .imm_i  (imm_i),
      .out_o  (res_o[e*4*DW +: 4*DW])
    );
    assign row1_res[e*2*DW +: 2*DW] = res_o[e*4*DW +: 2*DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= valid_i;
  end
endmodule

// File: rtl/xbar_datapath_chk.sv
module xbar_datapath_chk #(
  parameter int NUM_ELEM = 2,
  parameter int DW       = 16,
  parameter int DEPTH    = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int NNODE   = 4 * NUM_ELEM
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [NNODE*4-1:0]    node_op_i,
  input logic [NNODE-1:0]      wb_en_i,
  input logic [NNODE*AW-1:0]   wb_addr_i,
  input logic [NNODE*DW-1:0]   res_o,
  input logic                  done_o,
  input logic [DEPTH*DW-1:0]   rf_flat
);
  assert_done_after_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  assert_done_low_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  assert_bank_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(rf_flat));
  assert_no_enable_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wb_en_i == '0) |=> $stable(rf_flat));
  assert_top_port_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wb_en_i[NNODE-1]) |=>
      rf_flat[$past(wb_addr_i[(NNODE-1)*AW +: AW])*DW +: DW]
        == $past(res_o[(NNODE-1)*DW +: DW]));

  for (genvar n = 0; n < NNODE; n++) begin : g_off
    assert_idle_node_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (node_op_i[n*4 +: 4] == 4'd0) |-> (res_o[n*DW +: DW] == '0));
  end
endmodule

bind xbar_datapath xbar_datapath_chk #(
  .NUM_ELEM(NUM_ELEM), .DW(DW), .DEPTH(DEPTH)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .node_op_i (node_op_i),
  .wb_en_i   (wb_en_i),
  .wb_addr_i (wb_addr_i),
  .res_o     (res_o),
  .done_o    (done_o),
  .rf_flat   (rf_flat)
);

// File: tb/tb_xbar_datapath.sv
module tb_xbar_datapath;
  localparam int NE = 2, DW = 16, DEPTH = 16, AW = 4;
  localparam int NN = 4 * NE, NSRC = 2 * NE, SW = 3;

  logic clk = 1'b0, rst_ni = 1'b0, valid;
  logic [DW-1:0] imm;
  logic [NN*4-1:0] node_op;
  logic [NN*AW-1:0] opnd_addr, ext_addr, wb_addr;
  logic [NN*SW-1:0] xbar_sel;
  logic [NN*2-1:0] mux_sel;
  logic [NN-1:0] wb_en;
  logic [NN*DW-1:0] res;
  logic done;

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_rf [DEPTH];

  always #4 clk = ~clk;

  xbar_datapath #(.NUM_ELEM(NE), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .imm_i(imm),
    .node_op_i(node_op), .opnd_addr_i(opnd_addr), .ext_addr_i(ext_addr),
    .xbar_sel_i(xbar_sel), .mux_sel_i(mux_sel), .wb_en_i(wb_en),
    .wb_addr_i(wb_addr), .res_o(res), .done_o(done)
  );

  function automatic logic [15:0] vinit(int i);
    return 16'(16'h0007 + i * 16'h0123 + i * i * 16'h0041);
  endfunction

  function automatic logic [15:0] model(logic [3:0] op, logic [15:0] a, logic [15:0] b);
    logic [31:0] p;
    p = 32'(a) * 32'(b);
    case (op)
      4'd1: return a;
      4'd2: return a + b;
      4'd3: return a - b;
      4'd4: return p[15:0];
      4'd5: return a & b;
      4'd6: return a | b;
      4'd7: return a ^ b;
      4'd8: return a << b[3:0];
      4'd9: return a >> b[3:0];
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    valid = 0; imm = '0; node_op = '0; opnd_addr = '0; ext_addr = '0;
    xbar_sel = '0; mux_sel = '0; wb_en = '0; wb_addr = '0;
  endtask

  task automatic commit();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_reg(int addr, output logic [15:0] val);
    clr();
    node_op[3:0] = 4'd1;
    opnd_addr[3:0] = 4'(addr);
    #1;
    val = res[15:0];
  endtask

  task automatic verify_bank(string req);
    logic [15:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      read_reg(i, v);
      chk(req, 32'(v), 32'(exp_rf[i]));
    end
  endtask

  initial begin
    int unsigned guard = 0;
    while (guard < 200000) begin
      @(posedge clk);
      guard++;
    end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, ea, eb, chain, slot [NN];
    clr();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 done", 32'(done), 0);
    for (int i = 0; i < DEPTH; i++) exp_rf[i] = '0;
    verify_bank("R1");

    // R6/R3: load via immediate through upper node of element 0, slot 2
    for (int i = 0; i < DEPTH; i++) begin
      clr();
      imm = vinit(i);
      node_op[2*4 +: 4] = 4'd1;
      mux_sel[0 +: 2] = 2'd3;
      wb_en[2] = 1'b1;
      wb_addr[2*AW +: AW] = 4'(i);
      valid = 1'b1;
      commit();
      exp_rf[i] = vinit(i);
    end
    verify_bank("R6");

    // R2/R10: every op code on two first-row nodes
    for (int op = 0; op < 16; op++) begin
      for (int x = 0; x < DEPTH; x++) begin
        int y;
        y = (x * 5 + 3) % DEPTH;
        clr();
        node_op[0 +: 4] = 4'(op);
        opnd_addr[0*AW +: AW] = 4'(x);
        opnd_addr[1*AW +: AW] = 4'(y);
        node_op[5*4 +: 4] = 4'(op);
        opnd_addr[6*AW +: AW] = 4'(y);
        opnd_addr[7*AW +: AW] = 4'(x);
        #1;
        chk((op == 0 || op > 9) ? "R10" : "R2", 32'(res[0 +: 16]), 32'(model(4'(op), exp_rf[x], exp_rf[y])));
        chk((op == 0 || op > 9) ? "R10" : "R2", 32'(res[5*16 +: 16]), 32'(model(4'(op), exp_rf[y], exp_rf[x])));
      end
    end

    // R3: operand select sweep on element 0 upper-lower node (SUB)
    for (int sa = 0; sa < 4; sa++) begin
      for (int sb = 0; sb < 4; sb++) begin
        clr();
        imm = 16'h0BAD;
        node_op[0 +: 4] = 4'd1; opnd_addr[0 +: AW] = 4'd1;
        node_op[4 +: 4] = 4'd1; opnd_addr[2*AW +: AW] = 4'd2;
        ext_addr[0 +: AW] = 4'd3;
        ext_addr[AW +: AW] = 4'd4;
        node_op[2*4 +: 4] = 4'd3;
        mux_sel[0 +: 2] = 2'(sa);
        mux_sel[2 +: 2] = 2'(sb);
        #1;
        ea = (sa == 0) ? exp_rf[1] : (sa == 1) ? exp_rf[2] : (sa == 2) ? exp_rf[3] : 16'h0BAD;
        eb = (sb == 0) ? exp_rf[1] : (sb == 1) ? exp_rf[2] : (sb == 2) ? exp_rf[4] : 16'h0BAD;
        chk("R3", 32'(res[2*16 +: 16]), 32'(16'(ea - eb)));
      end
    end

    // R4: every crossbar destination against every select value
    for (int d = 0; d < NN; d++) begin
      for (int s = 0; s < 8; s++) begin
        int e, q, n;
        e = d / 4; q = d % 4; n = e * 4 + 2 + q / 2;
        clr();
        for (int ee = 0; ee < NE; ee++) begin
          for (int j = 0; j < 2; j++) begin
            node_op[(ee*4+j)*4 +: 4] = 4'd1;
            opnd_addr[(ee*4+j*2)*AW +: AW] = 4'(8 + ee*2 + j);
          end
        end
        xbar_sel[d*SW +: SW] = 3'(s);
        ext_addr[d*AW +: AW] = 4'(d);
        node_op[n*4 +: 4] = 4'd2;
        mux_sel[(e*4+q)*2 +: 2] = 2'd2;
        mux_sel[(e*4+(q^1))*2 +: 2] = 2'd3;
        #1;
        if (s == 0) ea = exp_rf[d];
        else if (s <= NSRC) ea = exp_rf[8 + s - 1];
        else ea = 16'h0;
        chk("R4", 32'(res[n*16 +: 16]), 32'(ea));
      end
    end

    // R5: chain across elements in one step, written back at the edge
    clr();
    node_op[0 +: 4] = 4'd4;
    opnd_addr[0 +: AW] = 4'd1; opnd_addr[AW +: AW] = 4'd2;
    node_op[4*4 +: 4] = 4'd1; opnd_addr[4*AW +: AW] = 4'd3;
    node_op[6*4 +: 4] = 4'd2;
    xbar_sel[4*SW +: SW] = 3'd1;
    mux_sel[4*2 +: 2] = 2'd2;
    mux_sel[5*2 +: 2] = 2'd0;
    wb_en[6] = 1'b1; wb_addr[6*AW +: AW] = 4'd10;
    valid = 1'b1;
    #1;
    chain = model(4'd4, exp_rf[1], exp_rf[2]) + exp_rf[3];
    chk("R5 same cycle", 32'(res[6*16 +: 16]), 32'(chain));
    commit();
    chk("R9 done after valid", 32'(done), 1);
    exp_rf[10] = chain;
    read_reg(10, v);
    chk("R5 written", 32'(v), 32'(chain));

    // R7: all ports write address 5, then ports 3 and 4 write address 9
    for (int pass = 0; pass < 2; pass++) begin
      clr();
      imm = 16'h0001;
      for (int ee = 0; ee < NE; ee++) begin
        node_op[(ee*4)*4 +: 4] = 4'd1;
        node_op[(ee*4+1)*4 +: 4] = 4'd1;
        opnd_addr[(ee*4)*AW +: AW] = 4'(11 + ee*2);
        opnd_addr[(ee*4+2)*AW +: AW] = 4'(12 + ee*2);
        node_op[(ee*4+2)*4 +: 4] = 4'd2;
        node_op[(ee*4+3)*4 +: 4] = 4'd3;
        mux_sel[(ee*4)*2 +: 2] = 2'd0;
        mux_sel[(ee*4+1)*2 +: 2] = 2'd3;
        mux_sel[(ee*4+2)*2 +: 2] = 2'd1;
        mux_sel[(ee*4+3)*2 +: 2] = 2'd3;
        slot[ee*4]   = exp_rf[11 + ee*2];
        slot[ee*4+1] = exp_rf[12 + ee*2];
        slot[ee*4+2] = exp_rf[11 + ee*2] + 16'd1;
        slot[ee*4+3] = exp_rf[12 + ee*2] - 16'd1;
      end
      for (int k = 0; k < NN; k++) wb_addr[k*AW +: AW] = (pass == 0) ? 4'd5 : 4'd9;
      wb_en = (pass == 0) ? '1 : 8'b0001_1000;
      valid = 1'b1;
      commit();
      if (pass == 0) exp_rf[5] = slot[7];
      else exp_rf[9] = slot[4];
      read_reg((pass == 0) ? 5 : 9, v);
      chk("R7", 32'(v), 32'((pass == 0) ? slot[7] : slot[4]));
    end

    // R8: enables high but step not valid
    clr();
    node_op[0 +: 4] = 4'd1; opnd_addr[0 +: AW] = 4'd0;
    node_op[2*4 +: 4] = 4'd1; mux_sel[0 +: 2] = 2'd3; imm = 16'hDEAD;
    wb_en = '1;
    for (int k = 0; k < NN; k++) wb_addr[k*AW +: AW] = 4'd6;
    commit();
    chk("R9 done low after idle", 32'(done), 0);
    verify_bank("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule